// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered clock, divided down to a sixteenth of the line rate, runs at the frequency that the local reference implies. It counts rising edges of the divided recovered clock over a window timed by the reference clock. At the end of each window it compares the count with the nominal count for the selected reference rate and drives an active-low status flag: low means lock is lost, high means the frequencies agree.

The flag has two thresholds. A frequency error of more than 1000 ppm of the nominal count drops the flag. The flag rises again only when the error is 500 ppm or less. An error between the two leaves the flag as it was. A select input tells the block whether the reference runs at a 64th or a 16th of the line rate, which makes the nominal count four times or one times the window length. The raw count of the most recent window is also brought out. The recovered-clock counter is passed into the reference domain in Gray code. The thresholds are computed at elaboration from the window length, so no divider is needed in hardware.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `lock_lost_n` is 0 and `window_count` is 0.
- R2: The first window after reset is only used as a baseline, so `lock_lost_n` stays 0 until at least two full windows have ended, even when the recovered clock is exact.
- R3: A window lasts 2^WIN_LOG2 reference cycles. `window_count` holds the number of recovered-clock rising edges counted in the latest complete window, within ±2.
- R4: When the absolute count error is above floor(nominal × 1000 / 10^6), `lock_lost_n` goes to 0 after that window. This holds for both a fast and a slow recovered clock.
- R5: When the absolute count error is at or below floor(nominal × 500 / 10^6), `lock_lost_n` goes to 1 after that window.
- R6: When the error lies between the two thresholds, `lock_lost_n` keeps its previous value, whether that value is 0 or 1.
- R7: With `ratio_sel` = 0 (reference at a 64th of the line rate) the nominal count is 4 × 2^WIN_LOG2. With `ratio_sel` = 1 (reference at a 16th) it is 1 × 2^WIN_LOG2. The thresholds scale with the nominal count.
- R8: If the recovered clock stops, `lock_lost_n` drops to 0 and `window_count` reads 0 no later than the second window end after it stops.
- R9: `lock_lost_n` and `window_count` change only in the cycle after a window end, and window ends are 2^WIN_LOG2 cycles apart.
- R10: The Gray-coded recovered-clock count changes in at most one bit per recovered-clock edge, so a value captured in the reference domain is never corrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the window and all outputs |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| vco_clk | input | 1 | Recovered clock divided to a sixteenth of the line rate |
| ratio_sel | input | 1 | 0: reference is a 64th of line rate; 1: a 16th |
| lock_lost_n | output | 1 | Active-low loss-of-lock flag (1 = locked) |
| window_count | output | WIN_LOG2+$clog2(RATIO_SLOW)+2 | Recovered-clock edges counted in the latest window |

## Verification
The hardest case to reach from the ports is the hold band. The count error must land between the two thresholds on every window, even though the phase between the clocks moves the count by one. To get there, the bench chooses recovered-clock periods whose ideal counts sit at least one count away from either threshold. It runs each period after both a locked and an unlocked history. Checking the update timing also needs the window phase, which cannot be seen directly. The bench finds it by stopping the recovered clock, noting the edge at which the count turns to zero, and restarting the clock in the middle of the next window.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic {
        LK_DOWN = 1'b0,
        LK_UP   = 1'b1
    } lock_e;

    typedef struct packed {
        logic too_far;
        logic close_enough;
    } verdict_t;

    // Error limit in counts for a nominal count and a ppm figure, floored.
    function automatic longint unsigned ppm_limit(input longint unsigned nominal,
                                                  input longint unsigned ppm);
        return (nominal * ppm) / 64'd1000000;
    endfunction

    // Counter width: the largest nominal count plus headroom for a fast clock.
    function automatic int count_width(input int win_log2, input int ratio_max);
        return win_log2 + $clog2(ratio_max) + 2;
    endfunction

endpackage

// File: rtl/fld_vco_count.sv
module fld_vco_count #(
    parameter int W = 18
) (
    input  logic         vco_clk,
    input  logic         rst_req,
    output logic [W-1:0] gray_q
);
    logic [1:0]   rst_pipe;
    logic         rst_v;
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nx;
    logic         arm_q;

    always_ff @(posedge vco_clk) begin
        rst_pipe <= {rst_pipe[0], rst_req};
    end
    assign rst_v  = rst_pipe[1];
    assign bin_nx = bin_q + W'(1);

    always_ff @(posedge vco_clk) begin
        if (rst_v) begin
            bin_q  <= '0;
            gray_q <= '0;
            arm_q  <= 1'b0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
            arm_q  <= 1'b1;
        end
    end

    // R10: the Gray word moves by at most one bit per edge.
    a_r10_gray_step: assert property (@(posedge vco_clk) disable iff (rst_v || !arm_q)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/fld_gray_rx.sv
module fld_gray_rx #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= gray_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        bin_out[W-1] = stage_q[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
        end
    end

endmodule

// File: rtl/fld_window.sv
module fld_window #(
    parameter int WIN_LOG2 = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick_q
);
    logic [WIN_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + WIN_LOG2'(1);
            tick_q <= (cnt_q == {WIN_LOG2{1'b1}});
        end
    end

    // R9: window ends never come back to back.
    a_r9_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

endmodule

// File: rtl/fld_judge.sv
module fld_judge
    import fld_pkg::*;
#(
    parameter int W          = 18,
    parameter int WIN_LOG2   = 14,
    parameter int RATIO_SLOW = 4,
    parameter int RATIO_FAST = 1,
    parameter int UNLOCK_PPM = 1000,
    parameter int LOCK_PPM   = 500
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ratio_sel,
    input  logic [W-1:0] cur_bin,
    output logic         lock_lost_n,
    output logic [W-1:0] meas_q
);
    localparam longint unsigned WINDOW   = 64'd1 << WIN_LOG2;
    localparam longint unsigned NOM_SLOW = WINDOW * longint'(RATIO_SLOW);
    localparam longint unsigned NOM_FAST = WINDOW * longint'(RATIO_FAST);
    localparam logic [W:0] NOM_SLOW_V = (W+1)'(NOM_SLOW);
    localparam logic [W:0] NOM_FAST_V = (W+1)'(NOM_FAST);
    localparam logic [W:0] UNL_SLOW_V = (W+1)'(ppm_limit(NOM_SLOW, longint'(UNLOCK_PPM)));
    localparam logic [W:0] UNL_FAST_V = (W+1)'(ppm_limit(NOM_FAST, longint'(UNLOCK_PPM)));
    localparam logic [W:0] LCK_SLOW_V = (W+1)'(ppm_limit(NOM_SLOW, longint'(LOCK_PPM)));
    localparam logic [W:0] LCK_FAST_V = (W+1)'(ppm_limit(NOM_FAST, longint'(LOCK_PPM)));

    lock_e        state_q;
    logic         primed_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] diff;
    logic [W:0]   nominal;
    logic [W:0]   unl_thr;
    logic [W:0]   lck_thr;
    logic [W+1:0] delta;
    logic [W:0]   err_abs;
    verdict_t     verdict;

    always_comb begin
        diff    = cur_bin - prev_q;
        nominal = ratio_sel ? NOM_FAST_V : NOM_SLOW_V;
        unl_thr = ratio_sel ? UNL_FAST_V : UNL_SLOW_V;
        lck_thr = ratio_sel ? LCK_FAST_V : LCK_SLOW_V;
        delta   = {2'b00, diff} - {1'b0, nominal};
        err_abs = delta[W+1] ? W'(0) - delta[W:0] : delta[W:0];
        if (delta[W+1]) err_abs = (W+1)'(0) - delta[W:0];
        else            err_abs = delta[W:0];
        verdict.too_far      = (err_abs > unl_thr);
        verdict.close_enough = (err_abs <= lck_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LK_DOWN;
            primed_q <= 1'b0;
            prev_q   <= '0;
            meas_q   <= '0;
        end else if (tick) begin
            prev_q   <= cur_bin;
            primed_q <= 1'b1;
            if (primed_q) begin
                meas_q <= diff;
                if (verdict.too_far)           state_q <= LK_DOWN;
                else if (verdict.close_enough) state_q <= LK_UP;
            end
        end
    end

    assign lock_lost_n = (state_q == LK_UP);

    // R1: reset leaves the flag low and the count cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!lock_lost_n && meas_q == '0));
    // R2: no lock decision before a baseline window exists.
    a_r2_baseline_first: assert property (@(posedge clk) disable iff (rst)
        !primed_q |=> !lock_lost_n);
    // R4: a large error drops the flag.
    a_r4_unlock_far: assert property (@(posedge clk) disable iff (rst)
        (tick && primed_q && verdict.too_far) |=> !lock_lost_n);
    // R5: a small error raises the flag.
    a_r5_relock_near: assert property (@(posedge clk) disable iff (rst)
        (tick && primed_q && verdict.close_enough) |=> lock_lost_n);
    // R6: inside the band the flag holds.
    a_r6_band_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && primed_q && !verdict.too_far && !verdict.close_enough) |=> $stable(lock_lost_n));
    // R9: outputs move only after a window end.
    a_r9_update_at_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(lock_lost_n) && $stable(meas_q)));

endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
    import fld_pkg::*;
#(
    parameter int WIN_LOG2    = 14,
    parameter int RATIO_SLOW  = 4,
    parameter int RATIO_FAST  = 1,
    parameter int UNLOCK_PPM  = 1000,
    parameter int LOCK_PPM    = 500,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = WIN_LOG2 + $clog2(RATIO_SLOW) + 2
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             vco_clk,
    input  logic             ratio_sel,
    output logic             lock_lost_n,
    output logic [CNT_W-1:0] window_count
);
    logic [CNT_W-1:0] vco_gray;
    logic [CNT_W-1:0] vco_bin_ref;
    logic             tick;

    fld_vco_count #(.W(CNT_W)) u_vco (
        .vco_clk (vco_clk),
        .rst_req (rst),
        .gray_q  (vco_gray)
    );

    fld_gray_rx #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_rx (
        .clk     (ref_clk),
        .rst     (rst),
        .gray_in (vco_gray),
        .bin_out (vco_bin_ref)
    );

    fld_window #(.WIN_LOG2(WIN_LOG2)) u_win (
        .clk    (ref_clk),
        .rst    (rst),
        .tick_q (tick)
    );

    fld_judge #(
        .W          (CNT_W),
        .WIN_LOG2   (WIN_LOG2),
        .RATIO_SLOW (RATIO_SLOW),
        .RATIO_FAST (RATIO_FAST),
        .UNLOCK_PPM (UNLOCK_PPM),
        .LOCK_PPM   (LOCK_PPM)
    ) u_judge (
        .clk         (ref_clk),
        .rst         (rst),
        .tick        (tick),
        .ratio_sel   (ratio_sel),
        .cur_bin     (vco_bin_ref),
        .lock_lost_n (lock_lost_n),
        .meas_q      (window_count)
    );

endmodule

// File: tb/sim_freq_lock_det.sv
`timescale 1ns/1ps
module sim_freq_lock_det;
    localparam int WL    = 12;
    localparam int WIN   = 1 << WL;
    localparam int CW    = WL + 2 + 2;
    localparam int NVEC  = 12;
    // Reference period 20000 ps; expected count = WIN*20000/period_ps.
    localparam int unsigned VEC_SEL  [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
    localparam int unsigned VEC_PER  [NVEC] = '{5000, 4990, 4996, 4998, 4996, 5010, 5000,
                                                20000, 19960, 19982, 20000, 19982};
    localparam int unsigned VEC_LOCK [NVEC] = '{1, 0, 0, 1, 1, 0, 1, 1, 0, 0, 1, 1};

    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic vco_clk = 1'b0;
    logic ratio_sel = 1'b0;
    logic lock_lost_n;
    logic [CW-1:0] window_count;

    bit          vco_run = 1'b1;
    int unsigned vco_per_ps = 5000;
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    freq_lock_det #(.WIN_LOG2(WL)) u0 (
        .ref_clk      (ref_clk),
        .rst          (rst),
        .vco_clk      (vco_clk),
        .ratio_sel    (ratio_sel),
        .lock_lost_n  (lock_lost_n),
        .window_count (window_count)
    );

    always #10 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (vco_run) begin
                vco_clk = 1'b1;
                #(real'(vco_per_ps) / 2000.0);
                vco_clk = 1'b0;
                #(real'(vco_per_ps) / 2000.0);
            end else begin
                vco_clk = 1'b0;
                #1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    function automatic bit near(input int a, input int e);
        return (a - e <= 2) && (e - a <= 2);
    endfunction

    initial begin
        int exp_cnt;
        int waited;
        // R1: reset state
        cyc(10);
        check(lock_lost_n == 1'b0, "R1 flag in reset", int'(lock_lost_n), 0);
        check(window_count == '0, "R1 count in reset", int'(window_count), 0);
        rst = 1'b0;
        cyc(1);
        check(lock_lost_n == 1'b0, "R1 flag after reset", int'(lock_lost_n), 0);
        check(window_count == '0, "R1 count after reset", int'(window_count), 0);
        // R2: exact clock, but only one window ended so far
        cyc(WIN + WIN / 2);
        check(lock_lost_n == 1'b0, "R2 baseline window", int'(lock_lost_n), 0);
        cyc(WIN / 2 + 12);
        check(lock_lost_n == 1'b1, "R2 lock after second window", int'(lock_lost_n), 1);

        // Vector walk: R3..R7
        for (int v = 0; v < NVEC; v++) begin
            ratio_sel  = VEC_SEL[v][0];
            vco_per_ps = VEC_PER[v];
            cyc(2 * WIN + 16);
            exp_cnt = (WIN * 20000) / int'(VEC_PER[v]);
            check(lock_lost_n == VEC_LOCK[v][0], "R4/R5/R6/R7 flag", int'(lock_lost_n), int'(VEC_LOCK[v]));
            check(near(int'(window_count), exp_cnt), "R3 count", int'(window_count), exp_cnt);
        end

        // R8: stopped recovered clock
        vco_run = 1'b0;
        waited = 0;
        while (window_count != '0 && waited < 3 * WIN) begin
            cyc(1);
            waited++;
        end
        check(waited <= 2 * WIN + 8, "R8 stop detected in time", waited, 2 * WIN);
        check(lock_lost_n == 1'b0, "R8 flag with stopped clock", int'(lock_lost_n), 0);
        check(window_count == '0, "R8 zero count", int'(window_count), 0);

        // R9: now aligned to a window end; restart mid-window
        cyc(WIN / 2);
        vco_per_ps = 20000;
        vco_run = 1'b1;
        cyc(WIN / 2 + 4);
        check(window_count != '0, "R9 partial window counted", int'(window_count), WIN / 2);
        check(lock_lost_n == 1'b0, "R9 partial window unlocked", int'(lock_lost_n), 0);
        cyc(WIN - 10);
        check(lock_lost_n == 1'b0, "R9 no change before window end", int'(lock_lost_n), 0);
        cyc(12);
        check(lock_lost_n == 1'b1, "R9 lock at window end", int'(lock_lost_n), 1);
        check(near(int'(window_count), WIN), "R9 count at window end", int'(window_count), WIN);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule